// File: doc/BRIEF.md
# Serial Bus Controller Interrupt Generator

This block sits beside the protocol engine of a multi-master, half-duplex serial bus controller and turns its single-cycle status pulses into interrupt requests. The engine reports four kinds of event: where it is in the frame, arbitration results, faults, and buffer handshakes. The engine also gives the node's current role: master or slave, transmitter or receiver, and individual or broadcast transfer. It also supplies the remaining counts of its byte and frame down-counters. Each event is qualified against this context before it raises anything.

There are six request classes: start, status transmission, end of frame, end of communication, transmit-data-write and receive-data-read. Each class latches into a sticky pending flag that is cleared by its own clear line. Each has an enable bit, and the interrupt output is the registered AND of the flag and its enable. Five fault conditions are merged into one communication-error request, which has its own pending flag and clear line.

Field encoding on `field_i`: 0 idle, 1 master address, 2 slave address, 3 control, 4 length, 5 data. Request index in `irq_o`, `en_i` and `clr_i`: 0 start, 1 status, 2 end of frame, 3 end of communication, 4 transmit-data-write, 5 receive-data-read.

Top module: `sbi_irq_gen`

## Requirements
- R1: `err_irq_o` rises two clock edges after any qualified fault pulse (timing, parity, NACK, underrun or overrun). It stays high until `err_clr_i` is asserted.
- R2: A timing error counts in every field and role. A parity error counts only while receiving (`is_tx_i`=0), in any field.
- R3: A NACK counts as a fault in a non-data field of an individual transfer (`is_bcast_i`=0), or in the data field (5) while transmitting. It counts in no other case.
- R4: An underrun counts only in the data field while transmitting. An overrun counts only in the data field while receiving.
- R5: As master (`is_master_i`=1), a lost-arbitration pulse during an active master request raises start (bit 0). A lost-arbitration pulse without a master request does not.
- R6: As slave, an address-match pulse in the slave-address field (2) raises start. The same pulse in the master role does not.
- R7: A status request pulse in the control field (3) raises status (bit 1). So does a NACK pulse in the control field. A status request in any other field does not.
- R8: A byte-done pulse with a byte count of zero raises end of frame (bit 2). If the frame count is also zero, it raises end of communication (bit 3) as well. A nonzero byte count raises neither.
- R9: A transmit-load pulse in the data field while transmitting raises transmit-data-write (bit 4) only when the byte count is nonzero. A zero count marks the last byte.
- R10: A receive-byte pulse in the data field while receiving raises receive-data-read (bit 5), unless a parity error or an overrun arrives in the same cycle.
- R11: Pending flags hold until their clear bit is asserted. When set and clear land in the same cycle, the flag stays set.
- R12: Each `irq_o` bit is the registered AND of its pending flag and `en_i` bit. All outputs are low after reset. A flag that became pending while its enable was low appears one edge after the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| field_i | input | 3 | Current frame field code |
| is_master_i | input | 1 | Node acts as master |
| is_tx_i | input | 1 | Node transmits |
| is_bcast_i | input | 1 | Broadcast transfer |
| timing_err_i | input | 1 | Timing error pulse |
| parity_err_i | input | 1 | Parity error pulse |
| nack_i | input | 1 | NACK received pulse |
| underrun_i | input | 1 | Transmit underrun pulse |
| overrun_i | input | 1 | Receive overrun pulse |
| mst_req_i | input | 1 | Master request active |
| lost_arb_i | input | 1 | Lost arbitration pulse |
| addr_match_i | input | 1 | Addressed as slave pulse |
| status_req_i | input | 1 | Status request pulse |
| byte_done_i | input | 1 | Byte completed pulse |
| tx_load_i | input | 1 | Transmit byte moved to shift register |
| rx_byte_i | input | 1 | Data byte received pulse |
| byte_cnt_i | input | BYTE_CNT_W | Remaining bytes in frame |
| frame_cnt_i | input | FRM_CNT_W | Remaining frames in communication |
| en_i | input | 6 | Per-request enable |
| clr_i | input | 6 | Per-request pending clear |
| err_clr_i | input | 1 | Error pending clear |
| irq_o | output | 6 | Interrupt requests |
| err_irq_o | output | 1 | Communication-error request |

## Verification
The bench builds the block with a 4-bit byte counter and a 3-bit frame counter. This lets it drive the counts to zero, to small nonzero values and to the maximum, so the last-byte and last-frame qualifiers are exercised next to their non-final neighbours. The table walks every fault against each role and field combination that should admit or reject it. Directed runs then cover enable masking with a held flag, stickiness over idle cycles, and set-versus-clear collisions.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  typedef enum logic [2:0] {
    FLD_IDLE  = 3'd0,
    FLD_MADDR = 3'd1,
    FLD_SADDR = 3'd2,
    FLD_CTRL  = 3'd3,
    FLD_LEN   = 3'd4,
    FLD_DATA  = 3'd5
  } fld_e;

  localparam int unsigned NUM_IRQ = 6;
  localparam int unsigned IRQ_START = 0;
  localparam int unsigned IRQ_STAT  = 1;
  localparam int unsigned IRQ_EOF   = 2;
  localparam int unsigned IRQ_EOC   = 3;
  localparam int unsigned IRQ_TXW   = 4;
  localparam int unsigned IRQ_RXR   = 5;
endpackage

// File: rtl/sbi_err_qual.sv
module sbi_err_qual
  import sbi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] field_i,
  input  logic       is_tx_i,
  input  logic       is_bcast_i,
  input  logic       timing_err_i,
  input  logic       parity_err_i,
  input  logic       nack_i,
  input  logic       underrun_i,
  input  logic       overrun_i,
  output logic       err_set_o
);
  logic in_data;
  logic q_tim, q_par, q_nack, q_und, q_ovr;

  assign in_data = (field_i == FLD_DATA);

  always_comb begin
    q_tim  = timing_err_i;
    q_par  = parity_err_i && !is_tx_i;
    q_nack = nack_i && ((!in_data && !is_bcast_i) || (in_data && is_tx_i));
    q_und  = underrun_i && in_data && is_tx_i;
    q_ovr  = overrun_i && in_data && !is_tx_i;
  end

  assign err_set_o = q_tim | q_par | q_nack | q_und | q_ovr;

  // R1
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_o |-> (timing_err_i || parity_err_i || nack_i || underrun_i || overrun_i));

  // R4
  und_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_i && !is_tx_i && !timing_err_i && !parity_err_i && !nack_i && !overrun_i)
      |-> !err_set_o);
endmodule

// File: rtl/sbi_evt_qual.sv
module sbi_evt_qual
  import sbi_pkg::*;
#(
  parameter int unsigned BYTE_CNT_W = 8,
  parameter int unsigned FRM_CNT_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            field_i,
  input  logic                  is_master_i,
  input  logic                  is_tx_i,
  input  logic                  mst_req_i,
  input  logic                  lost_arb_i,
  input  logic                  addr_match_i,
  input  logic                  status_req_i,
  input  logic                  nack_i,
  input  logic                  byte_done_i,
  input  logic                  tx_load_i,
  input  logic                  rx_byte_i,
  input  logic                  parity_err_i,
  input  logic                  overrun_i,
  input  logic [BYTE_CNT_W-1:0] byte_cnt_i,
  input  logic [FRM_CNT_W-1:0]  frame_cnt_i,
  output logic [NUM_IRQ-1:0]    set_o
);
  logic in_data, in_ctrl, in_saddr;
  logic byte_last, frame_last;

  assign in_data    = (field_i == FLD_DATA);
  assign in_ctrl    = (field_i == FLD_CTRL);
  assign in_saddr   = (field_i == FLD_SADDR);
  assign byte_last  = (byte_cnt_i == '0);
  assign frame_last = (frame_cnt_i == '0);

  always_comb begin
    set_o = '0;
    set_o[IRQ_START] = (is_master_i && mst_req_i && lost_arb_i)
                     || (!is_master_i && addr_match_i && in_saddr);
    set_o[IRQ_STAT]  = in_ctrl && (status_req_i || nack_i);
    set_o[IRQ_EOF]   = byte_done_i && byte_last;
    set_o[IRQ_EOC]   = byte_done_i && byte_last && frame_last;
    set_o[IRQ_TXW]   = tx_load_i && is_tx_i && in_data && !byte_last;
    set_o[IRQ_RXR]   = rx_byte_i && !is_tx_i && in_data && !parity_err_i && !overrun_i;
  end

  // R9
  last_txw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_i && byte_last) |-> !set_o[IRQ_TXW]);

  // R8
  eoc_in_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o[IRQ_EOC] |-> set_o[IRQ_EOF]);
endmodule

// File: rtl/sbi_pend_bank.sv
module sbi_pend_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_o[k] <= 1'b0;
      else if (set_i[k])  pend_o[k] <= 1'b1;
      else if (clr_i[k])  pend_o[k] <= 1'b0;
    end

    // R11
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> pend_o[k]);

    // R11
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[k] && !clr_i[k]) |=> pend_o[k]);
  end
endmodule

// File: rtl/sbi_irq_gen.sv
module sbi_irq_gen
  import sbi_pkg::*;
#(
  parameter int unsigned BYTE_CNT_W = 8,
  parameter int unsigned FRM_CNT_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            field_i,
  input  logic                  is_master_i,
  input  logic                  is_tx_i,
  input  logic                  is_bcast_i,
  input  logic                  timing_err_i,
  input  logic                  parity_err_i,
  input  logic                  nack_i,
  input  logic                  underrun_i,
  input  logic                  overrun_i,
  input  logic                  mst_req_i,
  input  logic                  lost_arb_i,
  input  logic                  addr_match_i,
  input  logic                  status_req_i,
  input  logic                  byte_done_i,
  input  logic                  tx_load_i,
  input  logic                  rx_byte_i,
  input  logic [BYTE_CNT_W-1:0] byte_cnt_i,
  input  logic [FRM_CNT_W-1:0]  frame_cnt_i,
  input  logic [5:0]            en_i,
  input  logic [5:0]            clr_i,
  input  logic                  err_clr_i,
  output logic [5:0]            irq_o,
  output logic                  err_irq_o
);
  logic [NUM_IRQ-1:0] evt_set, evt_pend;
  logic               err_set, err_pend;

  sbi_err_qual i_err_qual (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .field_i      (field_i),
    .is_tx_i      (is_tx_i),
    .is_bcast_i   (is_bcast_i),
    .timing_err_i (timing_err_i),
    .parity_err_i (parity_err_i),
    .nack_i       (nack_i),
    .underrun_i   (underrun_i),
    .overrun_i    (overrun_i),
    .err_set_o    (err_set)
  );

  sbi_evt_qual #(
    .BYTE_CNT_W (BYTE_CNT_W),
    .FRM_CNT_W  (FRM_CNT_W)
  ) i_evt_qual (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .field_i      (field_i),
    .is_master_i  (is_master_i),
    .is_tx_i      (is_tx_i),
    .mst_req_i    (mst_req_i),
    .lost_arb_i   (lost_arb_i),
    .addr_match_i (addr_match_i),
    .status_req_i (status_req_i),
    .nack_i       (nack_i),
    .byte_done_i  (byte_done_i),
    .tx_load_i    (tx_load_i),
    .rx_byte_i    (rx_byte_i),
    .parity_err_i (parity_err_i),
    .overrun_i    (overrun_i),
    .byte_cnt_i   (byte_cnt_i),
    .frame_cnt_i  (frame_cnt_i),
    .set_o        (evt_set)
  );

  sbi_pend_bank #(.N(NUM_IRQ)) i_evt_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (clr_i),
    .pend_o (evt_pend)
  );

  sbi_pend_bank #(.N(1)) i_err_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (err_clr_i),
    .pend_o (err_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= '0;
      err_irq_o <= 1'b0;
    end else begin
      irq_o     <= evt_pend & en_i;
      err_irq_o <= err_pend;
    end
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_mask_chk
    // R12
    mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[k] |=> !irq_o[k]);
  end

  // R1
  err_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set |=> ##1 err_irq_o);
endmodule

// File: tb/test_sbi_irq_gen.sv
module test_sbi_irq_gen;
  localparam int unsigned BW = 4;
  localparam int unsigned FW = 3;

  localparam logic [2:0] F_IDLE = 3'd0, F_MADDR = 3'd1, F_SADDR = 3'd2,
                         F_CTRL = 3'd3, F_LEN = 3'd4, F_DATA = 3'd5;

  localparam logic [11:0] E_TIM = 12'h800, E_PAR = 12'h400, E_NACK = 12'h200,
                          E_UND = 12'h100, E_OVR = 12'h080, E_LOST = 12'h040,
                          E_MREQ = 12'h020, E_AMAT = 12'h010, E_SREQ = 12'h008,
                          E_BDN = 12'h004, E_TXL = 12'h002, E_RXB = 12'h001;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  fld;
    logic        m;
    logic        tx;
    logic        bc;
    logic [11:0] ev;
    logic [3:0]  bcnt;
    logic [2:0]  fcnt;
    logic [5:0]  exp_irq;
    logic        exp_err;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VT [NV] = '{
    '{4'd2,  F_DATA,  1'b0, 1'b0, 1'b0, E_TIM,          4'd1, 3'd1, 6'b000000, 1'b1}, // R2
    '{4'd2,  F_CTRL,  1'b0, 1'b0, 1'b0, E_PAR,          4'd1, 3'd1, 6'b000000, 1'b1}, // R2
    '{4'd2,  F_CTRL,  1'b0, 1'b1, 1'b0, E_PAR,          4'd1, 3'd1, 6'b000000, 1'b0}, // R2
    '{4'd7,  F_CTRL,  1'b0, 1'b0, 1'b0, E_NACK,         4'd1, 3'd1, 6'b000010, 1'b1}, // R7
    '{4'd3,  F_LEN,   1'b0, 1'b0, 1'b1, E_NACK,         4'd1, 3'd1, 6'b000000, 1'b0}, // R3
    '{4'd3,  F_DATA,  1'b0, 1'b1, 1'b0, E_NACK,         4'd1, 3'd1, 6'b000000, 1'b1}, // R3
    '{4'd3,  F_DATA,  1'b0, 1'b0, 1'b0, E_NACK,         4'd1, 3'd1, 6'b000000, 1'b0}, // R3
    '{4'd4,  F_DATA,  1'b0, 1'b1, 1'b0, E_UND,          4'd1, 3'd1, 6'b000000, 1'b1}, // R4
    '{4'd4,  F_DATA,  1'b0, 1'b0, 1'b0, E_UND,          4'd1, 3'd1, 6'b000000, 1'b0}, // R4
    '{4'd4,  F_DATA,  1'b0, 1'b0, 1'b0, E_OVR,          4'd1, 3'd1, 6'b000000, 1'b1}, // R4
    '{4'd4,  F_DATA,  1'b0, 1'b1, 1'b0, E_OVR,          4'd1, 3'd1, 6'b000000, 1'b0}, // R4
    '{4'd5,  F_MADDR, 1'b1, 1'b1, 1'b0, E_LOST|E_MREQ,  4'd1, 3'd1, 6'b000001, 1'b0}, // R5
    '{4'd5,  F_MADDR, 1'b1, 1'b1, 1'b0, E_LOST,         4'd1, 3'd1, 6'b000000, 1'b0}, // R5
    '{4'd6,  F_SADDR, 1'b0, 1'b0, 1'b0, E_AMAT,         4'd1, 3'd1, 6'b000001, 1'b0}, // R6
    '{4'd6,  F_SADDR, 1'b1, 1'b0, 1'b0, E_AMAT,         4'd1, 3'd1, 6'b000000, 1'b0}, // R6
    '{4'd7,  F_CTRL,  1'b0, 1'b1, 1'b0, E_SREQ,         4'd1, 3'd1, 6'b000010, 1'b0}, // R7
    '{4'd7,  F_LEN,   1'b0, 1'b1, 1'b0, E_SREQ,         4'd1, 3'd1, 6'b000000, 1'b0}, // R7
    '{4'd8,  F_DATA,  1'b0, 1'b0, 1'b0, E_BDN,          4'd0, 3'd2, 6'b000100, 1'b0}, // R8
    '{4'd8,  F_DATA,  1'b0, 1'b1, 1'b0, E_BDN,          4'd0, 3'd0, 6'b001100, 1'b0}, // R8
    '{4'd8,  F_DATA,  1'b0, 1'b1, 1'b0, E_BDN,          4'd15,3'd0, 6'b000000, 1'b0}, // R8
    '{4'd9,  F_DATA,  1'b0, 1'b1, 1'b0, E_TXL,          4'd2, 3'd7, 6'b010000, 1'b0}, // R9
    '{4'd9,  F_DATA,  1'b0, 1'b1, 1'b0, E_TXL,          4'd0, 3'd7, 6'b000000, 1'b0}, // R9
    '{4'd10, F_DATA,  1'b0, 1'b0, 1'b0, E_RXB,          4'd3, 3'd1, 6'b100000, 1'b0}, // R10
    '{4'd10, F_DATA,  1'b0, 1'b0, 1'b0, E_RXB|E_PAR,    4'd3, 3'd1, 6'b000000, 1'b1}, // R10
    '{4'd1,  F_IDLE,  1'b1, 1'b1, 1'b0, E_TIM,          4'd1, 3'd1, 6'b000000, 1'b1}  // R1
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] field;
  logic is_master, is_tx, is_bcast;
  logic [11:0] ev;
  logic [BW-1:0] bcnt;
  logic [FW-1:0] fcnt;
  logic [5:0] en, clr;
  logic err_clr;
  logic [5:0] irq;
  logic err_irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sbi_irq_gen #(.BYTE_CNT_W(BW), .FRM_CNT_W(FW)) i_sbi_irq_gen (
    .clk_i (clk), .rst_ni (rst_n), .field_i (field),
    .is_master_i (is_master), .is_tx_i (is_tx), .is_bcast_i (is_bcast),
    .timing_err_i (ev[11]), .parity_err_i (ev[10]), .nack_i (ev[9]),
    .underrun_i (ev[8]), .overrun_i (ev[7]), .lost_arb_i (ev[6]),
    .mst_req_i (ev[5]), .addr_match_i (ev[4]), .status_req_i (ev[3]),
    .byte_done_i (ev[2]), .tx_load_i (ev[1]), .rx_byte_i (ev[0]),
    .byte_cnt_i (bcnt), .frame_cnt_i (fcnt),
    .en_i (en), .clr_i (clr), .err_clr_i (err_clr),
    .irq_o (irq), .err_irq_o (err_irq)
  );

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); clr = '1; err_clr = 1'b1;
    @(negedge clk); clr = '0; err_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    field = F_IDLE; is_master = 0; is_tx = 0; is_bcast = 0; ev = '0;
    bcnt = '1; fcnt = '1; en = '1; clr = '0; err_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset", {err_irq, irq}, 7'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      field = VT[i].fld; is_master = VT[i].m; is_tx = VT[i].tx; is_bcast = VT[i].bc;
      ev = VT[i].ev; bcnt = VT[i].bcnt; fcnt = VT[i].fcnt;
      @(negedge clk); ev = '0;
      @(negedge clk);
      chk($sformatf("R%0d vec %0d", VT[i].req, i), {err_irq, irq}, {VT[i].exp_err, VT[i].exp_irq});
      clear_all();
      chk($sformatf("R11 cleared after vec %0d", i), {err_irq, irq}, 7'b0);
    end

    // R12 masked flag held, shown when enabled
    en = 6'b111110; field = F_CTRL; is_tx = 1'b1;
    @(negedge clk); ev = E_SREQ;
    @(negedge clk); ev = '0; en = 6'b000000;
    @(negedge clk);
    chk("R12 masked", {1'b0, irq}, 7'b0);
    repeat (4) @(negedge clk);
    en = 6'b000010;
    @(negedge clk);
    chk("R12 enable reveals", {1'b0, irq}, 7'b0000010);
    en = '1;
    // R11 sticky over idle cycles
    repeat (6) @(negedge clk);
    chk("R11 sticky", {1'b0, irq}, 7'b0000010);
    // R11 set and clear together: set wins
    ev = E_SREQ; clr = 6'b000010;
    @(negedge clk); ev = '0; clr = '0;
    @(negedge clk);
    chk("R11 set wins", {1'b0, irq}, 7'b0000010);
    // R11 clear only its own bit
    field = F_DATA; is_tx = 1'b0; ev = E_RXB;
    @(negedge clk); ev = '0; clr = 6'b000010;
    @(negedge clk); clr = '0;
    @(negedge clk);
    chk("R11 selective clear", {1'b0, irq}, 7'b0100000);
    clear_all();
    // R1 error set wins over err_clr, then clears
    field = F_LEN; ev = E_TIM; err_clr = 1'b1;
    @(negedge clk); ev = '0; err_clr = 1'b0;
    @(negedge clk);
    chk("R1 err set wins", {err_irq, 6'b0}, 7'b1000000);
    repeat (3) @(negedge clk);
    chk("R1 err sticky", {err_irq, 6'b0}, 7'b1000000);
    err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    @(negedge clk);
    chk("R1 err cleared", {err_irq, irq}, 7'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule